// File: doc/BRIEF.md
# Wallace Tree Carry-Save Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. It builds all N×N AND terms, placing term a(j)·b(k) at weight 2^(j+k), so that row k is the multiplicand gated by multiplier bit k and shifted k places. It then shrinks the row set in parallel layers of 3:2 carry-save adders. Each adder turns three rows into a sum row (bitwise parity) and a carry row (bitwise majority, moved one place toward the MSB). Rows that do not fill a group of three go to the next layer unchanged, so a layer with r rows yields ceil(2r/3) rows. Once two rows remain, one carry-propagate adder forms the product. For N = 8 the row counts run 8, 6, 4, 3, 2, which is four layers.

Operands arrive on a valid/ready stream, and the product leaves on one. With `STAGE_REGS` = 1 (the default), a register follows each reduction layer. The whole pipeline advances on a cycle when the output is empty or the consumer is ready, and otherwise freezes. With `STAGE_REGS` = 0 the datapath is purely combinational: `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. `N` must be at least 3.

Top module: `wt_mult`

## Requirements
- R1: `product` equals the unsigned product `a*b` as a 2N-bit value for every operand pair, including 0 and the all-ones operands (255×255 = 65025 for N = 8).
- R2: With `STAGE_REGS` = 0, `product` reflects the present `a` and `b` in the same cycle, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`.
- R3: With `STAGE_REGS` = 1 and no back-pressure, a pair accepted at one rising edge appears on `out_valid`/`product` after exactly as many further edges as there are reduction layers, minus one, so it is visible 4 edges after acceptance counting the accepting edge, for N = 8.
- R4: While `rst_n` is low, `out_valid` is low on the cycle after each rising edge, and `in_ready` is high.
- R5: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `product` holds its value on the next cycle.
- R6: `in_ready` is high exactly when `out_ready` is high or `out_valid` is low.
- R7: Every accepted operand pair yields exactly one product on the output, and products leave in the same order in which the pairs were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the stage registers |
| rst_n | input | 1 | Active-low synchronous reset of the valid bits |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block takes the pair on this edge |
| a | input | N | Multiplicand, unsigned |
| b | input | N | Multiplier, unsigned |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product on this edge |
| product | output | 2N | Unsigned product a*b |

## Verification
The hardest condition to reach is a stall that freezes a pipeline holding valid results mixed with bubbles, with a new pair waiting at the input while `out_ready` is low. Only an irregular interleaving of `in_valid` and `out_ready` produces it. The stimulus drives both from a seeded random source at independent rates, so stalls land on every fill pattern of the four stages. A scoreboard queue checks order and completeness, and a final drain shows that nothing is stranded. The combinational build is swept over all 65536 operand pairs, which covers every carry pattern through the reduction layers.

// File: rtl/wt_mult_pkg.sv
package wt_mult_pkg;

  // rows left after one 3:2 layer: two per full group, leftovers pass through
  function automatic int next_rows(input int r);
    return (r / 3) * 2 + (r % 3);
  endfunction

  function automatic int layer_count(input int r);
    int c;
    int k;
    c = 0;
    k = r;
    while (k > 2) begin
      k = next_rows(k);
      c++;
    end
    return c;
  endfunction

  function automatic int rows_at(input int r, input int l);
    int k;
    k = r;
    for (int i = 0; i < l; i++) k = next_rows(k);
    return k;
  endfunction

  // first index of layer l's rows in a flat bank holding every layer in turn
  function automatic int row_base(input int r, input int l);
    int s;
    s = 0;
    for (int i = 0; i < l; i++) s += rows_at(r, i);
    return s;
  endfunction

endpackage

// File: rtl/wt_pp_gen.sv
module wt_pp_gen #(
  parameter int N = 8,
  parameter int W = 2 * N
) (
  input  logic [N-1:0]        a,
  input  logic [N-1:0]        b,
  output logic [N-1:0][W-1:0] rows
);
  for (genvar k = 0; k < N; k++) begin : g_row
    logic [W-1:0] gated;
    assign gated   = {{(W-N){1'b0}}, a & {N{b[k]}}};
    assign rows[k] = gated << k;
  end
endmodule

// File: rtl/wt_csa.sv
module wt_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sum,
  output logic [W-1:0] cry
);
  assign sum = x ^ y ^ z;
  // majority moved one place up; the top majority bit would exceed 2N bits
  assign cry = {(x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]), 1'b0};
endmodule

// File: rtl/wt_csa_layer.sv
module wt_csa_layer #(
  parameter int W   = 16,
  parameter int RIN = 8,
  localparam int GRP  = RIN / 3,
  localparam int LEFT = RIN % 3,
  localparam int ROUT = 2 * GRP + LEFT
) (
  input  logic [RIN-1:0][W-1:0]  din,
  output logic [ROUT-1:0][W-1:0] dout
);
  for (genvar g = 0; g < GRP; g++) begin : g_grp
    wt_csa #(.W(W)) u_csa (
      .x  (din[3*g]),
      .y  (din[3*g+1]),
      .z  (din[3*g+2]),
      .sum(dout[2*g]),
      .cry(dout[2*g+1])
    );
  end
  for (genvar r = 0; r < LEFT; r++) begin : g_pass
    assign dout[2*GRP+r] = din[3*GRP+r];
  end
endmodule

// File: rtl/wt_cpa.sv
module wt_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);
  assign s = x + y;
endmodule

// File: rtl/wt_mult.sv
module wt_mult
  import wt_mult_pkg::*;
#(
  parameter int N          = 8,
  parameter int STAGE_REGS = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [2*N-1:0] product
);
  localparam int W       = 2 * N;
  localparam int NL      = layer_count(N);
  localparam int SRC_TOT = row_base(N, NL + 1);
  localparam int CMB_TOT = SRC_TOT - N;
  localparam bit PIPED   = (STAGE_REGS != 0);

  if (N < 3) begin : g_bad_n
    $error("wt_mult needs N >= 3");
  end

  // src: inputs of each layer, then the final two rows; cmb: layer outputs
  logic [SRC_TOT-1:0][W-1:0] src;
  logic [CMB_TOT-1:0][W-1:0] cmb;

  wt_pp_gen #(.N(N), .W(W)) u_pp (
    .a   (a),
    .b   (b),
    .rows(src[N-1:0])
  );

  for (genvar l = 0; l < NL; l++) begin : g_layer
    localparam int RIN  = rows_at(N, l);
    localparam int ROUT = rows_at(N, l + 1);
    localparam int IB   = row_base(N, l);
    localparam int OB   = row_base(N, l + 1);
    wt_csa_layer #(.W(W), .RIN(RIN)) u_layer (
      .din (src[IB +: RIN]),
      .dout(cmb[OB - N +: ROUT])
    );
  end

  wt_cpa #(.W(W)) u_cpa (
    .x(src[SRC_TOT-2]),
    .y(src[SRC_TOT-1]),
    .s(product)
  );

  if (PIPED) begin : g_pipe
    logic [CMB_TOT-1:0][W-1:0] stg;
    logic [NL:1]               vld;
    logic                      adv;

    assign adv       = out_ready | ~vld[NL];
    assign in_ready  = adv;
    assign out_valid = vld[NL];
    assign src[SRC_TOT-1:N] = stg;

    always_ff @(posedge clk) begin
      if (adv) stg <= cmb;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld <= '0;
      end else if (adv) begin
        for (int i = 1; i <= NL; i++) vld[i] <= (i == 1) ? in_valid : vld[i-1];
      end
    end
  end else begin : g_comb
    assign src[SRC_TOT-1:N] = cmb;
    assign out_valid        = in_valid;
    assign in_ready         = out_ready;
  end

endmodule

// File: rtl/wt_mult_chk.sv
module wt_mult_chk #(
  parameter int N          = 8,
  parameter int STAGE_REGS = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           in_valid,
  input logic           in_ready,
  input logic [N-1:0]   a,
  input logic [N-1:0]   b,
  input logic           out_valid,
  input logic           out_ready,
  input logic [2*N-1:0] product
);
  if (STAGE_REGS != 0) begin : g_pipe_chk
    assert_reset_empty_R4: assert property (@(posedge clk)
      !rst_n |=> !out_valid);
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(product));
    assert_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |-> !in_ready);
    assert_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid || out_ready |-> in_ready);
  end else begin : g_comb_chk
    assert_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> product == ({{N{1'b0}}, a} * {{N{1'b0}}, b}));
    assert_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == in_valid) && (in_ready == out_ready));
  end
endmodule

bind wt_mult wt_mult_chk #(.N(N), .STAGE_REGS(STAGE_REGS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .a        (a),
  .b        (b),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .product  (product)
);

// File: tb/test_wt_mult.sv
module test_wt_mult;
  localparam int N = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  // pipelined build
  logic           in_valid = 1'b0, out_ready = 1'b0;
  logic [N-1:0]   a = '0, b = '0;
  logic           in_ready, out_valid;
  logic [2*N-1:0] product;

  // combinational build
  logic           c_in_valid = 1'b0, c_out_ready = 1'b0;
  logic [N-1:0]   ca = '0, cb = '0;
  logic           c_in_ready, c_out_valid;
  logic [2*N-1:0] c_product;

  int total = 0;
  int bad   = 0;
  logic [2*N-1:0] sb[$];

  wt_mult #(.N(N), .STAGE_REGS(1)) i_wt_mult (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .out_valid(out_valid), .out_ready(out_ready), .product(product)
  );

  wt_mult #(.N(N), .STAGE_REGS(0)) i_wt_mult_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(c_in_valid), .in_ready(c_in_ready),
    .a(ca), .b(cb), .out_valid(c_out_valid), .out_ready(c_out_ready), .product(c_product)
  );

  function automatic logic [2*N-1:0] ref_mul(input logic [N-1:0] x, input logic [N-1:0] y);
    logic [2*N-1:0] acc = '0;
    for (int k = 0; k < N; k++) if (y[k]) acc += ({{N{1'b0}}, x} << k);
    return acc;
  endfunction

  task automatic check(input string req, input logic [2*N-1:0] act, input logic [2*N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #1_500_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic held;
    logic [2*N-1:0] held_p;
    void'($urandom(32'h5EED_0042));
    // R4: reset state
    repeat (3) @(negedge clk);
    check("R4 out_valid in reset", {15'd0, out_valid}, 16'd0);
    check("R4 in_ready in reset", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: latency with no back-pressure
    out_ready = 1'b1;
    in_valid  = 1'b1; a = 8'd200; b = 8'd100;
    @(negedge clk);
    in_valid = 1'b0;
    for (int c = 1; c <= 3; c++) begin
      check("R3 not yet valid", {15'd0, out_valid}, 16'd0);
      if (c < 3) @(negedge clk);
    end
    @(negedge clk);
    check("R3 valid after four edges", {15'd0, out_valid}, 16'd1);
    check("R3 product", product, 16'd20000);
    @(negedge clk);
    check("R3 single result", {15'd0, out_valid}, 16'd0);

    // R1, R2: exhaustive sweep of the combinational build
    for (int i = 0; i < (1 << (2 * N)); i++) begin
      ca = i[N-1:0];
      cb = i[2*N-1:N];
      c_in_valid  = i[0];
      c_out_ready = i[1];
      #1;
      check("R1 comb product", c_product, ref_mul(ca, cb));
      if (i[5:0] == 6'd0) begin
        check("R2 out_valid follows in_valid", {15'd0, c_out_valid}, {15'd0, c_in_valid});
        check("R2 in_ready follows out_ready", {15'd0, c_in_ready}, {15'd0, c_out_ready});
      end
    end

    // R1, R5, R6, R7: random stream with back-pressure and corner operands
    @(negedge clk);
    held = 1'b0;
    held_p = '0;
    for (int t = 0; t < 3000; t++) begin
      if (held) begin
        check("R5 valid held", {15'd0, out_valid}, 16'd1);
        check("R5 product held", product, held_p);
      end
      in_valid  = ($urandom % 10) < 7;
      out_ready = ($urandom % 10) < 6;
      case ($urandom % 8)
        0: begin a = '0; b = N'($urandom); end
        1: begin a = '1; b = '1; end
        2: begin a = N'($urandom); b = '1; end
        default: begin a = N'($urandom); b = N'($urandom); end
      endcase
      #1;
      check("R6 in_ready", {15'd0, in_ready}, {15'd0, (out_ready | ~out_valid)});
      if (out_valid && out_ready) begin
        if (sb.size() == 0) check("R7 unexpected output", product, 16'hxxxx);
        else check("R1 R7 stream product", product, sb.pop_front());
      end
      if (in_valid && in_ready) sb.push_back(ref_mul(a, b));
      held   = out_valid && !out_ready;
      held_p = product;
      @(negedge clk);
    end

    // R7: drain
    in_valid = 1'b0;
    out_ready = 1'b1;
    for (int t = 0; t < 10; t++) begin
      #1;
      if (out_valid) begin
        if (sb.size() == 0) check("R7 extra output", product, 16'hxxxx);
        else check("R1 R7 drain product", product, sb.pop_front());
      end
      @(negedge clk);
    end
    check("R7 nothing left", 16'(sb.size()), 16'd0);
    finish_run();
  end
endmodule